// File: doc/BRIEF.md
# Two-Level Tree Magnitude Comparator

This block compares two unsigned operands of parameterised width and reports whether the first is greater than, equal to, or less than the second. It does not pass a result bit by bit through a long chain of slices. Instead it builds a shallow tree out of one reusable 4-bit cascadable comparator slice.

In the first level, each operand is cut into groups that are compared in parallel. The lowest group is four bits wide. Its slice has its cascade inputs fixed to "equal", so its greater and less results are never both high. Every higher group is five bits wide. Its lowest bit enters the slice through the cascade inputs: the operand-A bit drives greater-in, the operand-B bit drives less-in, and equal-in is held low.

In the second level, each group's greater and less flags become one A bit and one B bit of a merge slice, at the position that matches the group's significance. Merge slices are chained from the least significant one upward, and the most significant one gives the result. Operand bits above the width are filled with zero for both operands. The result flags are registered and appear one clock after the operands are sampled.

Top module: `wide_mag_cmp`

## Requirements
- R1: While the synchronous active-high reset is sampled high on a rising clock edge, the outputs become gt_o=0, eq_o=1, lt_o=0.
- R2: Operands sampled on a rising edge are reflected on the outputs right after that same edge, with a latency of one clock and no other delay.
- R3: gt_o is 1 exactly when a_in is greater than b_in, with both read as unsigned integers.
- R4: lt_o is 1 exactly when a_in is less than b_in, with both read as unsigned.
- R5: eq_o is 1 exactly when a_in equals b_in, and this includes the all-zero and all-ones operand pairs.
- R6: Outside reset, exactly one of gt_o, eq_o and lt_o is 1 in every cycle.
- R7: When the operands differ only in bit W-1, that bit alone decides the result, whatever the lower bits are.
- R8: When the operands differ only inside bits 3..0 (the lowest group, which uses fixed cascade inputs), the result still follows the unsigned order.
- R9: When the operands differ only in bit 4+5k (the lowest bit of five-bit group k+1, which enters its slice through the cascade inputs), the result follows that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Operand A, unsigned |
| b_in | input | W | Operand B, unsigned |
| gt_o | output | 1 | Registered flag, A greater than B |
| eq_o | output | 1 | Registered flag, A equal to B |
| lt_o | output | 1 | Registered flag, A less than B |

## Verification
Every result flag is due one clock after its operands are sampled. The bench drives a new operand pair on a falling edge, so the next rising edge captures it. The bench then reads all three flags on the following falling edge, before it drives the next pair. This gives every pair exactly the one-register latency, and no check samples at a clock edge. The reset value is read on the falling edge after a rising edge at which reset was high.

// File: rtl/wide_cmp_pkg.sv
package wide_cmp_pkg;

  localparam int unsigned SLICE_W = 4;
  localparam int unsigned GROUP_W = SLICE_W + 1;

  // first group is a plain 4-bit slice, every other group is 5 bits
  function automatic int unsigned grp_count(input int unsigned w);
    if (w <= SLICE_W) return 1;
    return 1 + (w - SLICE_W + GROUP_W - 1) / GROUP_W;
  endfunction

  function automatic int unsigned padded_w(input int unsigned w);
    return SLICE_W + GROUP_W * (grp_count(w) - 1);
  endfunction

  function automatic int unsigned merge_count(input int unsigned groups);
    return (groups + SLICE_W - 1) / SLICE_W;
  endfunction

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import wide_cmp_pkg::*;
(
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  cmp_flags_t         cin,
  output cmp_flags_t         cout
);

  always_comb begin
    cout = '0;
    if (a > b) begin
      cout.gt = 1'b1;
    end else if (a < b) begin
      cout.lt = 1'b1;
    end else if (cin.eq) begin
      cout.eq = 1'b1;
    end else begin
      // feed-forward behaviour with equal-in low
      cout.gt = ~cin.lt;
      cout.lt = ~cin.gt;
    end
  end

endmodule

// File: rtl/cmp_group_stage.sv
module cmp_group_stage
  import wide_cmp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned NG = grp_count(W),
  localparam int unsigned PW = padded_w(W)
) (
  input  logic [PW-1:0] a_pad,
  input  logic [PW-1:0] b_pad,
  output logic [NG-1:0] grp_gt,
  output logic [NG-1:0] grp_lt
);

  localparam cmp_flags_t SERIAL_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cmp_flags_t res;
    if (g == 0) begin : g_serial
      cmp_slice u_slice (
        .a    (a_pad[SLICE_W-1:0]),
        .b    (b_pad[SLICE_W-1:0]),
        .cin  (SERIAL_TIE),
        .cout (res)
      );
    end else begin : g_five
      localparam int unsigned BASE = SLICE_W + GROUP_W * (g - 1);
      cmp_flags_t extra;
      always_comb begin
        extra.gt = a_pad[BASE];
        extra.eq = 1'b0;
        extra.lt = b_pad[BASE];
      end
      cmp_slice u_slice (
        .a    (a_pad[BASE+1 +: SLICE_W]),
        .b    (b_pad[BASE+1 +: SLICE_W]),
        .cin  (extra),
        .cout (res)
      );
    end
    assign grp_gt[g] = res.gt;
    assign grp_lt[g] = res.lt;
  end

endmodule

// File: rtl/cmp_merge_stage.sv
module cmp_merge_stage
  import wide_cmp_pkg::*;
#(
  parameter int unsigned NG = 7,
  localparam int unsigned NS = merge_count(NG),
  localparam int unsigned MW = NS * SLICE_W
) (
  input  logic [NG-1:0] grp_gt,
  input  logic [NG-1:0] grp_lt,
  output cmp_flags_t    result
);

  localparam cmp_flags_t SERIAL_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  logic [MW-1:0] gt_ext;
  logic [MW-1:0] lt_ext;
  cmp_flags_t    chain [NS+1];

  assign gt_ext   = MW'(grp_gt);
  assign lt_ext   = MW'(grp_lt);
  assign chain[0] = SERIAL_TIE;

  for (genvar s = 0; s < NS; s++) begin : g_merge
    cmp_slice u_slice (
      .a    (gt_ext[s*SLICE_W +: SLICE_W]),
      .b    (lt_ext[s*SLICE_W +: SLICE_W]),
      .cin  (chain[s]),
      .cout (chain[s+1])
    );
  end

  assign result = chain[NS];

endmodule

// File: rtl/wide_mag_cmp.sv
module wide_mag_cmp
  import wide_cmp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         gt_o,
  output logic         eq_o,
  output logic         lt_o
);

  localparam int unsigned NG = grp_count(W);
  localparam int unsigned PW = padded_w(W);

  logic [PW-1:0] a_pad;
  logic [PW-1:0] b_pad;
  logic [NG-1:0] grp_gt;
  logic [NG-1:0] grp_lt;
  cmp_flags_t    tree_res;

  assign a_pad = PW'(a_in);
  assign b_pad = PW'(b_in);

  cmp_group_stage #(.W(W)) u_groups (
    .a_pad  (a_pad),
    .b_pad  (b_pad),
    .grp_gt (grp_gt),
    .grp_lt (grp_lt)
  );

  cmp_merge_stage #(.NG(NG)) u_merge (
    .grp_gt (grp_gt),
    .grp_lt (grp_lt),
    .result (tree_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gt_o <= 1'b0;
      eq_o <= 1'b1;
      lt_o <= 1'b0;
    end else begin
      gt_o <= tree_res.gt;
      eq_o <= tree_res.eq;
      lt_o <= tree_res.lt;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (eq_o && !gt_o && !lt_o)); // R1

  AST_GT_ORDER: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (gt_o == ($past(a_in) > $past(b_in)))); // R3

  AST_LT_ORDER: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (lt_o == ($past(a_in) < $past(b_in)))); // R4

  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (eq_o == ($past(a_in) == $past(b_in)))); // R5

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $countones({gt_o, eq_o, lt_o}) == 1); // R6

  AST_LOW_GROUP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grp_gt[0] && grp_lt[0])); // R8

endmodule

// File: tb/test_wide_mag_cmp.sv
module test_wide_mag_cmp;

  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         gt_o, eq_o, lt_o;

  int unsigned total = 0;
  int unsigned bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wide_mag_cmp #(.W(W)) i_wide_mag_cmp (
    .clk  (clk),
    .rst  (rst),
    .a_in (a_in),
    .b_in (b_in),
    .gt_o (gt_o),
    .eq_o (eq_o),
    .lt_o (lt_o)
  );

  function automatic logic [2:0] expect_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a > b) return 3'b100;
    if (a < b) return 3'b001;
    return 3'b010;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    total++;
    if ({gt_o, eq_o, lt_o} !== exp) begin
      bad++;
      $display("FAIL %s: got gt/eq/lt=%b expected %b (a=%h b=%h)",
               req, {gt_o, eq_o, lt_o}, exp, a_in, b_in);
    end
  endtask

  // drive on a falling edge, read on the next falling edge (one register)
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(negedge clk);
    a_in = a;
    b_in = b;
    @(negedge clk);
    check(req, expect_flags(a, b));
  endtask

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", 3'b010);
    a_in = 32'hFFFF_0000;
    b_in = 32'h0000_0001;
    @(negedge clk);
    check("R1", 3'b010);
    rst = 1'b0;
    @(negedge clk);
    check("R2", 3'b100);

    apply('0, '0, "R5");
    apply('1, '1, "R5");
    apply('1, '0, "R3");
    apply('0, '1, "R4");
    apply(32'h8000_0000, 32'h7FFF_FFFF, "R7");
    apply(32'h7FFF_FFFF, 32'h8000_0000, "R7");
    apply(32'h0000_0001, 32'h0000_0000, "R8");
    apply(32'hA5A5_A5A0, 32'hA5A5_A5AF, "R8");
    apply(32'h0000_0008, 32'h0000_0007, "R8");
    for (int k = 0; k < 6; k++) begin
      ra = $urandom();
      rb = ra;
      ra[4+5*k] = 1'b1;
      rb[4+5*k] = 1'b0;
      apply(ra, rb, "R9");
      apply(rb, ra, "R9");
    end
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom();
      case ($urandom_range(0, 3))
        0: rb = ra;
        1: rb = ra ^ (32'h1 << $urandom_range(0, W-1));
        default: rb = $urandom();
      endcase
      apply(ra, rb, (ra > rb) ? "R3" : (ra < rb) ? "R4" : "R5");
    end
    // R2: back-to-back pairs, each due one clock after it is sampled
    @(negedge clk);
    a_in = 32'd5; b_in = 32'd9;
    @(negedge clk);
    check("R2", 3'b001);
    a_in = 32'd9; b_in = 32'd5;
    @(negedge clk);
    check("R2", 3'b100);
    // reset during operation
    a_in = 32'd3; b_in = 32'd1;
    rst = 1'b1;
    @(negedge clk);
    check("R1", 3'b010);
    rst = 1'b0;
    @(negedge clk);
    check("R6", 3'b100);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule